// File: doc/BRIEF.md
# Sequential Hi/Lo Multiply-Divide Unit

This unit performs 32-bit integer multiplication and division for a RISC core, one bit per clock. Results go into a private pair of result registers, named Hi and Lo, and do not appear on a result bus. The core copies them into its register file later, through a read port.

A multiply writes the full 64-bit product as two words. A divide writes the quotient to Lo and the remainder to Hi. Each operation has a signed and an unsigned variant. A signed operation works on operand magnitudes and corrects the signs at the end.

Operations are started with a one-cycle strobe. The busy flag tells the core when Hi and Lo are about to change. While the unit is busy, the read port keeps returning the previous results.

Top module: `muldiv_hilo`

## Requirements
- R1: With `op_i` = 2'b01 (unsigned multiply), the 64-bit product of the operands is written with its upper word in Hi and its lower word in Lo.
- R2: With `op_i` = 2'b00 (signed multiply), both operands are treated as two's complement, and the 64-bit two's-complement product is written in the same Hi/Lo split as R1.
- R3: With `op_i` = 2'b11 (unsigned divide), Lo receives the quotient and Hi receives the remainder.
- R4: With `op_i` = 2'b10 (signed divide):
  - The quotient is truncated toward zero.
  - The remainder carries the sign of the dividend.
  - The most negative dividend divided by -1 yields Lo = 32'h8000_0000 and Hi = 0.
- R5: A divide by zero, signed or unsigned, takes the normal number of steps and leaves Lo = 32'hFFFF_FFFF and Hi equal to the dividend.
- R6: Busy timing is fixed:
  - A start accepted at a clock edge raises `busy_o` from that edge on.
  - `busy_o` stays high for exactly 32 cycles.
  - The new Hi/Lo values are readable in the first cycle with `busy_o` low.
- R7: `rd_data_o` shows Hi when `rd_hi_i` = 1 and Lo when `rd_hi_i` = 0, in the same cycle. Reading never changes either register.
- R8: While `busy_o` is high, the read port returns the results of the previous operation.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It neither restarts nor lengthens the running operation, and it does not change its results.
- R10: After reset, Hi = 0, Lo = 0 and `busy_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that begins an operation when the unit is idle |
| op_i | input | 2 | Operation select: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a_i | input | 32 | First operand (multiplicand or dividend) |
| src_b_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | High while an operation is in progress |
| rd_hi_i | input | 1 | Read select: 1 picks Hi, 0 picks Lo |
| rd_data_o | output | 32 | Selected result register |

## Verification
The hardest conditions to create are the ones where the unit must not act:
- a second start strobe arriving in the middle of a running operation;
- a read that lands in the window just before the results are written.

To reach these, the driver fires a second strobe with different operands several cycles into an operation. The monitor then checks that the busy window is still exactly 32 cycles and that the first operation's results arrive. On every busy cycle the monitor also alternates the read select and compares against the previously committed pair.

Divide-by-zero and the signed overflow case (most negative value divided by -1) are driven directly, because the sign fix-up treats them differently from ordinary divides.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;

    // Sign fix-up flags captured when an operation is accepted
    typedef struct packed {
        logic is_div;
        logic neg_prod;
        logic neg_quot;
        logic neg_rem;
    } md_flags_t;

endpackage

// File: rtl/md_prep.sv
module md_prep
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output md_flags_t    flags_o
);

    logic sgn;
    logic a_neg;
    logic b_neg;
    logic b_zero;

    always_comb begin
        sgn     = ~op_i[0];
        a_neg   = sgn & a_i[W-1];
        b_neg   = sgn & b_i[W-1];
        b_zero  = (b_i == '0);
        mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
        flags_o.is_div   = op_i[1];
        flags_o.neg_prod = a_neg ^ b_neg;
        // A zero divisor keeps the all-ones quotient unsigned-looking
        flags_o.neg_quot = (a_neg ^ b_neg) & ~b_zero;
        flags_o.neg_rem  = a_neg;
    end

endmodule

// File: rtl/md_engine.sv
module md_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         is_div_i,
    input  logic [W-1:0] mag_a_i,
    input  logic [W-1:0] mag_b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] mq_o
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          is_div;
        logic [CW-1:0] cnt;
        logic [W-1:0]  acc;
        logic [W-1:0]  mq;
        logic [W-1:0]  opnd;
    } eng_t;

    eng_t q, d;
    logic [W:0] msum;
    logic [W:0] dshift;
    logic [W:0] ddiff;

    always_comb begin
        d      = q;
        msum   = {1'b0, q.acc} + (q.mq[0] ? {1'b0, q.opnd} : '0);
        dshift = {q.acc, q.mq[W-1]};
        ddiff  = dshift - {1'b0, q.opnd};
        if (!q.busy) begin
            if (start_i) begin
                d.busy   = 1'b1;
                d.is_div = is_div_i;
                d.cnt    = '0;
                d.acc    = '0;
                d.mq     = mag_a_i;
                d.opnd   = mag_b_i;
            end
        end else begin
            if (q.is_div) begin
                d.acc = ddiff[W] ? dshift[W-1:0] : ddiff[W-1:0];
                d.mq  = {q.mq[W-2:0], ~ddiff[W]};
            end else begin
                d.acc = msum[W:1];
                d.mq  = {msum[0], q.mq[W-1:1]};
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign done_o = q.busy && (q.cnt == LAST);
    assign acc_o  = d.acc;
    assign mq_o   = d.mq;

    // R6: an accepted start begins a fresh count
    assert_start_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !q.busy) |=> (q.busy && q.cnt == '0));

    // R6: busy cannot drop before the final step
    assert_no_early_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != LAST) |=> q.busy);

    // R9: a start during busy does not disturb the step count
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start_i && q.cnt != LAST) |=> (q.cnt == $past(q.cnt) + 1'b1));

endmodule

// File: rtl/md_fix.sv
module md_fix
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_flags_t    flags_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mq_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    logic [2*W-1:0] prod;

    always_comb begin
        prod = {acc_i, mq_i};
        if (flags_i.neg_prod) begin
            prod = ~prod + 1'b1;
        end
        if (flags_i.is_div) begin
            lo_o = flags_i.neg_quot ? (~mq_i + 1'b1) : mq_i;
            hi_o = flags_i.neg_rem  ? (~acc_i + 1'b1) : acc_i;
        end else begin
            hi_o = prod[2*W-1:W];
            lo_o = prod[W-1:0];
        end
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] src_a_i,
    input  logic [W-1:0] src_b_i,
    output logic         busy_o,
    input  logic         rd_hi_i,
    output logic [W-1:0] rd_data_o
);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        md_flags_t    flags;
    } top_t;

    top_t q, d;

    logic [W-1:0] mag_a, mag_b;
    md_flags_t    flags_new;
    logic         eng_busy, eng_done;
    logic [W-1:0] eng_acc, eng_mq;
    logic [W-1:0] fix_hi, fix_lo;

    md_prep #(.W(W)) u_prep (
        .op_i    (op_i),
        .a_i     (src_a_i),
        .b_i     (src_b_i),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .flags_o (flags_new)
    );

    md_engine #(.W(W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .is_div_i (flags_new.is_div),
        .mag_a_i  (mag_a),
        .mag_b_i  (mag_b),
        .busy_o   (eng_busy),
        .done_o   (eng_done),
        .acc_o    (eng_acc),
        .mq_o     (eng_mq)
    );

    md_fix #(.W(W)) u_fix (
        .flags_i (q.flags),
        .acc_i   (eng_acc),
        .mq_i    (eng_mq),
        .hi_o    (fix_hi),
        .lo_o    (fix_lo)
    );

    always_comb begin
        d = q;
        if (start_i && !eng_busy) begin
            d.flags = flags_new;
        end
        if (eng_done) begin
            d.hi = fix_hi;
            d.lo = fix_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = eng_busy;
    assign rd_data_o = rd_hi_i ? q.hi : q.lo;

    // R8: Hi changes only at the edge where busy falls
    assert_hi_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hi != $past(q.hi)) |-> $fell(eng_busy));

    // R8: Lo changes only at the edge where busy falls
    assert_lo_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lo != $past(q.lo)) |-> $fell(eng_busy));

    // R7: the read port mirrors the selected register
    assert_read_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |-> (rd_data_o == q.hi));

endmodule

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic        busy_o;
    logic        rd_hi_i = 1'b0;
    logic [31:0] rd_data_o;

    always #2 clk = ~clk;

    muldiv_hilo u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .busy_o    (busy_o),
        .rd_hi_i   (rd_hi_i),
        .rd_data_o (rd_data_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_hi = '0;
    logic [31:0] last_lo = '0;
    bit          mon_en = 1'b0;
    int          busy_len = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        logic signed [63:0] sa, sb, sq, sr;
        logic [63:0] r;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        case (op)
            2'b01: r = {32'b0, a} * {32'b0, b};
            2'b00: r = sa * sb;
            2'b11: r = (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
            default: begin
                if (b == 0) begin
                    r = {a, 32'hFFFF_FFFF};
                end else begin
                    sq = sa / sb;
                    sr = sa % sb;
                    r  = {sr[31:0], sq[31:0]};
                end
            end
        endcase
        return r;
    endfunction

    // Driver: issues one operation, optionally with a stray start mid-way
    task automatic run_op(input string tag, input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b, input bit intrude);
        @(negedge clk);
        start_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b;
        exp_q.push_back(model(op, a, b));
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 busy after start", {31'b0, busy_o}, 32'd1);
        if (intrude) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; op_i = ~op; src_a_i = ~a; src_b_i = 32'd3;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        @(negedge clk);
        chk("R9 no queued restart", {31'b0, busy_o}, 32'd0);
    endtask

    // Monitor: compares committed results and checks reads during busy
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (busy_o) begin
                    busy_len++;
                    rd_hi_i = busy_len[0];
                    #1;
                    chk("R8 read while busy", rd_data_o, rd_hi_i ? last_hi : last_lo);
                end else if (busy_len != 0) begin
                    logic [63:0] e;
                    string t;
                    chk("R6 busy length", busy_len, 32'd32);
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    rd_hi_i = 1'b1; #1;
                    chk({t, " Hi"}, rd_data_o, e[63:32]);
                    rd_hi_i = 1'b0; #1;
                    chk({t, " Lo"}, rd_data_o, e[31:0]);
                    rd_hi_i = 1'b1; #1;
                    chk("R7 reread Hi unchanged", rd_data_o, e[63:32]);
                    last_hi = e[63:32];
                    last_lo = e[31:0];
                    busy_len = 0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_hi_i = 1'b1; #1;
        chk("R10 Hi reset", rd_data_o, 32'd0);
        rd_hi_i = 1'b0; #1;
        chk("R10 Lo reset", rd_data_o, 32'd0);
        chk("R10 busy reset", {31'b0, busy_o}, 32'd0);
        mon_en = 1'b1;

        run_op("R1 unsigned mul", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op("R1 unsigned mul small", 2'b01, 32'd12345, 32'd6789, 1'b0);
        run_op("R2 signed mul neg*pos", 2'b00, 32'hFFFF_FFF9, 32'd1000, 1'b0);
        run_op("R2 signed mul neg*neg", 2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op("R2 signed mul pattern", 2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
        run_op("R3 unsigned div", 2'b11, 32'hFFFF_FFFF, 32'd10, 1'b0);
        run_op("R3 unsigned div big divisor", 2'b11, 32'h8000_0001, 32'hC000_0000, 1'b0);
        run_op("R4 signed div neg/pos", 2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op("R4 signed div pos/neg", 2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_op("R4 signed div min/-1", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op("R5 unsigned div by zero", 2'b11, 32'hDEAD_BEEF, 32'd0, 1'b0);
        run_op("R5 signed div by zero", 2'b10, 32'hFFFF_FFFB, 32'd0, 1'b0);
        run_op("R9 intruded mul", 2'b01, 32'hCAFE_0001, 32'h0000_0101, 1'b1);
        run_op("R9 intruded div", 2'b10, 32'hF000_0000, 32'd7, 1'b1);

        repeat (4) @(negedge clk);
        rd_hi_i = 1'b0; #1;
        chk("R7 Lo held after idle", rd_data_o, last_lo);
        rd_hi_i = 1'b1; #1;
        chk("R7 Hi held after idle", rd_data_o, last_hi);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule